// File: doc/BRIEF.md
# Dual-Mode PWM / Input-Capture Timer Channel

This block is a single 16-bit timer channel with two modes. As a PWM generator it counts up from zero to a programmed period. It drives its output high while the count is below a programmed duty threshold. As an input-capture unit it lets the counter run freely and stores the count when a rising edge arrives on either of two capture pins. Software reaches four word-wide registers through a small bus made of an address, a write strobe, write data and combinational read data.

In PWM mode the period and duty values each have two copies. Software writes a shadow copy, and the comparator uses an active copy. While the counter runs, both active copies reload from their shadows only at the clock on which the counter wraps. While the counter is stopped, a write reaches the active copy at once. Reads always return the shadow copy, which is the value last written or captured. The counter can be loaded only while both run bits are clear. In capture mode the two shadow registers act as capture registers, and a capture beats a software write made in the same cycle.

Top module: `pwmcap_timer`

## Requirements
- R1: After reset the control, counter, period and duty registers all read 0, and `pwm_o` is 0.
- R2: Address 1 reads the current counter. The counter steps by one on every clock while control bit 1 or control bit 2 (or both) is set.
- R3: A write to address 1 loads the counter only while control bits 1 and 2 are both clear. At any other time the write is ignored.
- R4: In PWM mode (control bit 0 = 0) with the counter running, a counter equal to the active period becomes 0 on the next clock. That clock is the reload point.
- R5: A write to the period register (address 2) while running does not change the wrap point until the next reload point.
- R6: A write to the duty register (address 3) while running does not change `pwm_o` until the next reload point.
- R7: While stopped, a period or duty write becomes active on the clock of the write.
- R8: Reads of addresses 2 and 3 return the value most recently written or captured, even if it is not yet active.
- R9: `pwm_o` is 1 exactly when the block is in PWM mode and the counter is below the active duty. A duty of 0 therefore holds the output low, and a duty above the period holds it high. The output is 0 in capture mode.
- R10: In capture mode (control bit 0 = 1), each capture pin passes through a two-stage synchronizer. A rising edge at the synchronizer output loads the counter value of that cycle: `cap_i[0]` loads address 2 and `cap_i[1]` loads address 3.
- R11: When a capture and a software write to the same register fall on the same clock, the captured value is kept.
- R12: Address 0 is the control register: bit 0 selects the mode, bits 1 and 2 are the two run bits, and the upper bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Write strobe |
| bus_addr | input | 2 | Register address (0 control, 1 counter, 2 period, 3 duty) |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for `bus_addr`, combinational |
| cap_i | input | 2 | Asynchronous capture pins |
| pwm_o | output | 1 | PWM output |

## Verification
A wrong shadow or active copy becomes visible at the ports in two ways. An early reload moves the wrap point or a `pwm_o` edge inside the current period. A read of address 2 or 3 straight after a write returns the wrong value in that same cycle. A counter fault appears on the next counter read and shifts `pwm_o` within one period. A capture fault appears on the read of address 2 or 3 three clocks after the pin edge. The bench runs a cycle-level model in parallel with the design and compares `pwm_o` and the addressed read value on every clock, so most faults are reported within a cycle or two of their first effect.

// File: rtl/pwmcap_pkg.sv
package pwmcap_pkg;
    localparam int ADDR_W = 2;

    localparam logic [ADDR_W-1:0] A_CTRL   = 2'd0;
    localparam logic [ADDR_W-1:0] A_COUNT  = 2'd1;
    localparam logic [ADDR_W-1:0] A_PERIOD = 2'd2;
    localparam logic [ADDR_W-1:0] A_DUTY   = 2'd3;

    localparam int CTRL_W = 3;

    typedef struct packed {
        logic run_b;
        logic run_a;
        logic cap_mode;
    } ctrl_t;
endpackage

// File: rtl/pwmcap_edge_sync.sv
module pwmcap_edge_sync #(
    parameter int N_PINS = 2,
    parameter int STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_PINS-1:0] pin_i,
    output logic [N_PINS-1:0] rise_o
);
    for (genvar g = 0; g < N_PINS; g++) begin : g_pin
        typedef struct packed {
            logic [STAGES-1:0] sh;
            logic              prev;
        } sync_t;

        sync_t st_d, st_q;

        always_comb begin
            st_d      = st_q;
            st_d.sh   = {st_q.sh[STAGES-2:0], pin_i[g]};
            st_d.prev = st_q.sh[STAGES-1];
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) st_q <= '0;
            else        st_q <= st_d;
        end

        assign rise_o[g] = st_q.sh[STAGES-1] & ~st_q.prev;

        // R10
        single_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
            rise_o[g] |=> !rise_o[g]);
    end
endmodule

// File: rtl/pwmcap_counter.sv
module pwmcap_counter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         running,
    input  logic         pwm_mode,
    input  logic [W-1:0] period_act,
    input  logic         wr_en,
    input  logic [W-1:0] wr_data,
    output logic [W-1:0] cnt_o,
    output logic         wrap_o
);
    typedef struct packed {
        logic [W-1:0] cnt;
    } cnt_st_t;

    cnt_st_t st_d, st_q;
    logic    wrap;

    always_comb begin
        st_d = st_q;
        wrap = running && pwm_mode && (st_q.cnt == period_act);
        if (running) begin
            if (wrap) st_d.cnt = '0;
            else      st_d.cnt = st_q.cnt + 1'b1;
        end else if (wr_en) begin
            st_d.cnt = wr_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cnt_o  = st_q.cnt;
    assign wrap_o = wrap;

    // R2
    count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        running |=> (cnt_o == W'($past(cnt_o) + 1'b1)) || (cnt_o == '0));

    // R3
    stopped_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!running && wr_en) |=> cnt_o == $past(wr_data));

    // R4
    period_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (running && pwm_mode && cnt_o == period_act) |=> cnt_o == '0);
endmodule

// File: rtl/pwmcap_shadow_reg.sv
module pwmcap_shadow_reg #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         cap_mode,
    input  logic         cap_evt,
    input  logic         running,
    input  logic         reload,
    input  logic [W-1:0] cnt_i,
    input  logic         wr_en,
    input  logic [W-1:0] wr_data,
    output logic [W-1:0] shadow_o,
    output logic [W-1:0] active_o
);
    typedef struct packed {
        logic [W-1:0] shadow;
        logic [W-1:0] active;
    } sh_st_t;

    sh_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (cap_mode && cap_evt) st_d.shadow = cnt_i;
        else if (wr_en)          st_d.shadow = wr_data;

        if (!running)    st_d.active = st_d.shadow;
        else if (reload) st_d.active = st_q.shadow;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign shadow_o = st_q.shadow;
    assign active_o = st_q.active;

    // R5 R6
    hold_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (running && !reload) |=> $stable(active_o));

    // R7
    stopped_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!running && wr_en && !(cap_mode && cap_evt)) |=> active_o == $past(wr_data));

    // R10 R11
    capture_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_mode && cap_evt) |=> shadow_o == $past(cnt_i));
endmodule

// File: rtl/pwmcap_timer.sv
module pwmcap_timer
    import pwmcap_pkg::*;
#(
    parameter int W           = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [W-1:0]      bus_wdata,
    output logic [W-1:0]      bus_rdata,
    input  logic [1:0]        cap_i,
    output logic              pwm_o
);
    localparam int N_CMP = 2;

    ctrl_t ctrl_d, ctrl_q;

    logic             running;
    logic             pwm_mode;
    logic [W-1:0]     cnt;
    logic             wrap;
    logic [N_CMP-1:0] cap_rise;
    logic [W-1:0]     shadow [N_CMP];
    logic [W-1:0]     active [N_CMP];

    always_comb begin
        ctrl_d = ctrl_q;
        if (bus_we && bus_addr == A_CTRL) ctrl_d = ctrl_t'(bus_wdata[CTRL_W-1:0]);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctrl_q <= '0;
        else        ctrl_q <= ctrl_d;
    end

    assign running  = ctrl_q.run_a | ctrl_q.run_b;
    assign pwm_mode = ~ctrl_q.cap_mode;

    pwmcap_edge_sync #(.N_PINS(N_CMP), .STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .pin_i  (cap_i),
        .rise_o (cap_rise)
    );

    pwmcap_counter #(.W(W)) u_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .running    (running),
        .pwm_mode   (pwm_mode),
        .period_act (active[0]),
        .wr_en      (bus_we && bus_addr == A_COUNT),
        .wr_data    (bus_wdata),
        .cnt_o      (cnt),
        .wrap_o     (wrap)
    );

    for (genvar k = 0; k < N_CMP; k++) begin : g_cmp
        localparam logic [ADDR_W-1:0] MY_ADDR = A_PERIOD + ADDR_W'(k);
        pwmcap_shadow_reg #(.W(W)) u_reg (
            .clk      (clk),
            .rst_n    (rst_n),
            .cap_mode (ctrl_q.cap_mode),
            .cap_evt  (cap_rise[k]),
            .running  (running),
            .reload   (wrap),
            .cnt_i    (cnt),
            .wr_en    (bus_we && bus_addr == MY_ADDR),
            .wr_data  (bus_wdata),
            .shadow_o (shadow[k]),
            .active_o (active[k])
        );
    end

    always_comb begin
        case (bus_addr)
            A_CTRL:   bus_rdata = W'(ctrl_q);
            A_COUNT:  bus_rdata = cnt;
            A_PERIOD: bus_rdata = shadow[0];
            default:  bus_rdata = shadow[1];
        endcase
    end

    assign pwm_o = pwm_mode & (cnt < active[1]);

    // R9
    capture_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_q.cap_mode |-> !pwm_o);

    // R9
    zero_duty_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (active[1] == '0) |-> !pwm_o);

    // R12
    ctrl_readback_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == A_CTRL) |=> W'(ctrl_q) == W'($past(bus_wdata[CTRL_W-1:0])));
endmodule

// File: tb/pwmcap_timer_bench.sv
`timescale 1ns/1ps
module pwmcap_timer_bench;
    import pwmcap_pkg::*;
    localparam int W = 16;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         we = 1'b0;
    logic [1:0]   addr = 2'd0;
    logic [W-1:0] wdata = '0;
    logic [1:0]   cap = 2'b00;
    logic [W-1:0] rdata;
    logic         pwm;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    pwmcap_timer u_pwmcap_timer (
        .clk(clk), .rst_n(rst_n), .bus_we(we), .bus_addr(addr),
        .bus_wdata(wdata), .bus_rdata(rdata), .cap_i(cap), .pwm_o(pwm)
    );

    logic [W-1:0] m_cnt = '0;
    logic [W-1:0] m_sh [2] = '{'0, '0};
    logic [W-1:0] m_act [2] = '{'0, '0};
    logic [2:0]   m_ctrl = '0;
    logic [1:0]   m_s0 = '0, m_s1 = '0, m_prev = '0;

    function automatic logic [W-1:0] exp_read(input logic [1:0] a);
        case (a)
            2'd0:    return W'(m_ctrl);
            2'd1:    return m_cnt;
            2'd2:    return m_sh[0];
            default: return m_sh[1];
        endcase
    endfunction

    function automatic logic exp_pwm();
        return !m_ctrl[0] && (m_cnt < m_act[1]);
    endfunction

    task automatic model_edge();
        logic run, wrap;
        logic [1:0] rise;
        logic [W-1:0] n_sh [2];
        logic [W-1:0] n_act [2];
        logic [W-1:0] n_cnt;
        run  = m_ctrl[1] | m_ctrl[2];
        rise = m_s1 & ~m_prev;
        wrap = run && !m_ctrl[0] && (m_cnt == m_act[0]);
        if (run) n_cnt = wrap ? '0 : m_cnt + 1'b1;
        else     n_cnt = (we && addr == 2'd1) ? wdata : m_cnt;
        for (int k = 0; k < 2; k++) begin
            if (m_ctrl[0] && rise[k])          n_sh[k] = m_cnt;
            else if (we && addr == 2'(2 + k))  n_sh[k] = wdata;
            else                               n_sh[k] = m_sh[k];
            if (!run)      n_act[k] = n_sh[k];
            else if (wrap) n_act[k] = m_sh[k];
            else           n_act[k] = m_act[k];
        end
        if (we && addr == 2'd0) m_ctrl = wdata[2:0];
        m_cnt = n_cnt;
        for (int k = 0; k < 2; k++) begin
            m_sh[k]  = n_sh[k];
            m_act[k] = n_act[k];
        end
        m_prev = m_s1;
        m_s1   = m_s0;
        m_s0   = cap;
    endtask

    task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic tick();
        string t;
        @(posedge clk);
        model_edge();
        @(negedge clk);
        case (addr)
            2'd0:    t = "R12 ctrl read";
            2'd1:    t = "R2 counter read";
            default: t = "R8 shadow read";
        endcase
        check(t, rdata, exp_read(addr));
        check("R9 pwm output", W'(pwm), W'(exp_pwm()));
    endtask

    task automatic wr(input logic [1:0] a, input logic [W-1:0] d);
        we = 1'b1; addr = a; wdata = d;
        tick();
        we = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, input string tag, input logic [W-1:0] exp);
        addr = a;
        #1;
        check(tag, rdata, exp);
    endtask

    task automatic wait_cnt(input logic [W-1:0] v, input string tag);
        int n = 0;
        addr = 2'd1;
        #1;
        while (m_cnt != v && n < 200) begin
            tick();
            n++;
        end
        check(tag, rdata, v);
    endtask

    initial begin
        #(200000 * 20);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [W-1:0] r;
        void'($urandom(32'd20240611));
        @(negedge clk);
        @(negedge clk);
        for (int a = 0; a < 4; a++) rd(2'(a), "R1 reset value", '0);
        check("R1 reset pwm", W'(pwm), '0);
        rst_n = 1'b1;
        @(negedge clk);

        wr(A_PERIOD, 16'd9);
        wr(A_DUTY, 16'd4);
        rd(A_DUTY, "R8 read after write", 16'd4);
        check("R7 stopped duty active", W'(pwm), 16'd1);
        wr(A_COUNT, 16'd3);
        rd(A_COUNT, "R3 stopped count load", 16'd3);
        wr(A_COUNT, 16'd0);
        wr(A_CTRL, 16'h0002);
        rd(A_CTRL, "R12 ctrl bits", 16'h0002);
        tick(); tick();
        r = m_cnt;
        wr(A_COUNT, 16'h1234);
        rd(A_COUNT, "R3 running count write ignored", r + 1'b1);

        wait_cnt(16'd9, "R4 reach period");
        tick();
        rd(A_COUNT, "R4 wrap to zero", 16'd0);

        wait_cnt(16'd2, "R6 setup");
        wr(A_DUTY, 16'd7);
        rd(A_DUTY, "R8 pending duty read", 16'd7);
        wait_cnt(16'd5, "R6 setup");
        check("R6 old duty still active", W'(pwm), 16'd0);
        wait_cnt(16'd0, "R6 wrap");
        wait_cnt(16'd5, "R6 setup");
        check("R6 new duty after wrap", W'(pwm), 16'd1);

        wait_cnt(16'd2, "R5 setup");
        wr(A_PERIOD, 16'd5);
        rd(A_PERIOD, "R8 pending period read", 16'd5);
        wait_cnt(16'd9, "R5 old period kept");
        tick();
        rd(A_COUNT, "R5 wrap at old period", 16'd0);
        wait_cnt(16'd5, "R5 setup");
        tick();
        rd(A_COUNT, "R5 wrap at new period", 16'd0);

        wr(A_DUTY, 16'd0);
        wait_cnt(16'd5, "R9 setup");
        tick();
        for (int i = 0; i < 6; i++) begin
            check("R9 zero duty low", W'(pwm), 16'd0);
            tick();
        end
        wr(A_DUTY, 16'd20);
        wait_cnt(16'd5, "R9 setup");
        tick();
        for (int i = 0; i < 6; i++) begin
            check("R9 duty above period high", W'(pwm), 16'd1);
            tick();
        end

        wr(A_CTRL, 16'h0000);
        wr(A_COUNT, 16'd0);
        wr(A_CTRL, 16'h0004);
        tick(); tick();
        rd(A_COUNT, "R2 run_b alone counts", 16'd2);

        wr(A_CTRL, 16'h0003);
        rd(A_CTRL, "R12 capture mode bits", 16'h0003);
        tick(); tick(); tick();
        check("R9 capture mode low", W'(pwm), 16'd0);
        cap = 2'b01;
        tick(); tick();
        r = m_cnt;
        tick();
        rd(A_PERIOD, "R10 capture pin 0", r);
        cap = 2'b11;
        tick(); tick();
        r = m_cnt;
        wr(A_DUTY, 16'hBEEF);
        rd(A_DUTY, "R11 capture beats write", r);
        cap = 2'b00;
        tick(); tick();

        for (int i = 0; i < 4000; i++) begin
            logic [31:0] x;
            x = $urandom;
            we = (x[2:0] == 3'd0);
            addr = x[4:3];
            if (addr == A_CTRL) wdata = W'(x[7:5]) | 16'h0100;
            else                wdata = W'(x[12:8]);
            if (x[15:13] == 3'd0) cap[0] = ~cap[0];
            if (x[18:16] == 3'd0) cap[1] = ~cap[1];
            tick();
            we = 1'b0;
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule